// File: doc/BRIEF.md
# Gated Free-Running Timer Counter

This block is the time base of a timer subsystem. A 16-bit up counter moves forward once per prescaler period, where the prescaler divides the bus clock by a fixed power of two. Software controls the counter through two word-wide registers on a simple zero-wait-state bus. The first is a control word holding an enable flag, a halt-during-wait flag and a precision-select flag that can be written once. The second is the count itself. Any agent can read the count. A write to the count only takes effect while the chip is in its privileged test mode.

Two outputs serve neighbouring logic. The first is a one-cycle pulse produced once every 64 prescaler periods, which feeds a pulse accumulator. The second is a level that tells the accumulator and a modulus down counter to stop while the chip waits with the halt flag set. Clearing the enable flag freezes the counter, the prescaler phase and the accumulator pulse, and saves power.

Top module: `gated_tick_timer`

## Requirements
- R1: After reset the control word and the count both read 0, and `acc_tick_o` and `acc_stop_o` are low.
- R2: While running, the count goes up by exactly one at the end of every prescaler period (4 bus clocks with the default `PRE_LOG2` = 2). It wraps from 0xFFFF to 0x0000.
- R3: While the enable flag (control bit 0) is 0, the count, the prescaler phase and the divide-by-64 phase all hold, and `acc_tick_o` stays low.
- R4: With the halt flag (control bit 1) at 1 and `wait_i` high, the count holds and `acc_stop_o` is high. With the halt flag at 0, counting continues while `wait_i` is high and `acc_stop_o` stays low.
- R5: A write to the count (address 1) while `test_mode_i` is low leaves the count unchanged.
- R6: Precision select (control bit 2) accepts only the first control write after reset. Every later control write leaves it as it was, while still updating bits 0 and 1.
- R7: `acc_tick_o` is a one-cycle pulse. It is high in the bus cycle that ends the 64th prescaler period since the previous pulse, and only while the counter is running.
- R8: A count write while `test_mode_i` is high loads the written value at the next clock edge. The load takes priority over an increment in the same cycle, and it does not reset the prescaler phase, so the next increment can come after less than a full period.
- R9: Address 0 selects the control word and address 1 selects the count. Control bits above bit 2 read as 0. `rd_data_o` is 0 whenever `bus_valid_i` is low, and reads respond in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| test_mode_i | input | 1 | Privileged test mode; enables writes to the count |
| wait_i | input | 1 | Chip is in its low-power wait state |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 1 | 0 = control word, 1 = count |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data, same cycle, 0 when idle |
| acc_tick_o | output | 1 | One-cycle pulse every 64 prescaler periods |
| acc_stop_o | output | 1 | Stop request to accumulator and modulus logic |

## Verification
A wrong prescaler or counter state shows up as a count read that is off by one or more within a single prescaler period, so the bench reads the count on every bus cycle around enables, loads and wraps. A corrupted divide-by-64 phase would move the accumulator pulse, which the bench compares on every cycle, so the error is visible within at most 256 clocks. A broken precision lock, or a gate that leaks, shows up on the next read of the control word, or the next read of the count during a stall.

// File: rtl/gtt_pkg.sv
package gtt_pkg;
  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_HALT_BIT = 1;
  localparam int unsigned CTRL_PREC_BIT = 2;
  localparam int unsigned CTRL_BITS     = CTRL_PREC_BIT + 1;
  localparam int unsigned ACC_LOG2      = 6;

  typedef struct packed {
    logic prec;
    logic halt;
    logic en;
  } ctrl_t;

  typedef enum logic {
    SEL_CTRL  = 1'b0,
    SEL_COUNT = 1'b1
  } sel_e;
endpackage

// File: rtl/gtt_divider.sv
// Power-of-two phase divider: tick_o marks the step that closes a period.
module gtt_divider #(
  parameter int unsigned LOG2 = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  output logic tick_o
);
  logic [LOG2-1:0] phase_q;
  logic [LOG2-1:0] phase_d;

  always_comb begin
    phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (step_i) begin
      phase_q <= phase_d;
    end
  end

  assign tick_o = step_i && (&phase_q);
endmodule

// File: rtl/gtt_count_reg.sv
// Count register: load wins over increment.
module gtt_count_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_ce;

  always_comb begin
    cnt_ce = load_i || inc_i;
    if (load_i) begin
      cnt_d = load_val_i;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/gtt_ctrl_reg.sv
// Control word with a write-once precision flag.
module gtt_ctrl_reg
  import gtt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic [CTRL_BITS-1:0] wdata_i,
  output ctrl_t                ctrl_o
);
  ctrl_t ctrl_q;
  ctrl_t ctrl_d;
  logic  lock_q;

  always_comb begin
    ctrl_d      = ctrl_q;
    ctrl_d.en   = wdata_i[CTRL_EN_BIT];
    ctrl_d.halt = wdata_i[CTRL_HALT_BIT];
    if (!lock_q) begin
      ctrl_d.prec = wdata_i[CTRL_PREC_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      lock_q <= 1'b0;
    end else if (wr_i) begin
      ctrl_q <= ctrl_d;
      lock_q <= 1'b1;
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/gated_tick_timer.sv
module gated_tick_timer
  import gtt_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PRE_LOG2 = 2,
  parameter int unsigned ACC_DIV_LOG2 = ACC_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_mode_i,
  input  logic             wait_i,
  input  logic             bus_valid_i,
  input  logic             bus_write_i,
  input  logic             bus_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             acc_tick_o,
  output logic             acc_stop_o
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_n_sync;
  ctrl_t                  ctrl;
  logic                   ctrl_wr;
  logic                   cnt_wr;
  logic                   halted;
  logic                   running;
  logic                   pre_tick;
  logic [CNT_W-1:0]       count_q;
  sel_e                   sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_n_sync = rst_pipe_q[SYNC_STAGES-1];

  assign sel     = sel_e'(bus_addr_i);
  assign ctrl_wr = bus_valid_i && bus_write_i && (sel == SEL_CTRL);
  assign cnt_wr  = bus_valid_i && bus_write_i && (sel == SEL_COUNT) && test_mode_i;

  gtt_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_i    (ctrl_wr),
    .wdata_i (wr_data_i[CTRL_BITS-1:0]),
    .ctrl_o  (ctrl)
  );

  assign halted     = ctrl.halt && wait_i;
  assign running    = ctrl.en && !halted;
  assign acc_stop_o = halted;

  gtt_divider #(.LOG2(PRE_LOG2)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .step_i (running),
    .tick_o (pre_tick)
  );

  gtt_divider #(.LOG2(ACC_DIV_LOG2)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .step_i (pre_tick),
    .tick_o (acc_tick_o)
  );

  gtt_count_reg #(.W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .load_i     (cnt_wr),
    .load_val_i (wr_data_i),
    .inc_i      (pre_tick),
    .count_o    (count_q)
  );

  always_comb begin
    rd_data_o = '0;
    if (bus_valid_i) begin
      case (sel)
        SEL_COUNT: rd_data_o = count_q;
        default: begin
          rd_data_o[CTRL_EN_BIT]   = ctrl.en;
          rd_data_o[CTRL_HALT_BIT] = ctrl.halt;
          rd_data_o[CTRL_PREC_BIT] = ctrl.prec;
        end
      endcase
    end
  end
endmodule

// File: rtl/gtt_checker.sv
module gtt_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             prec,
  input logic             prec_lock,
  input logic             pre_tick,
  input logic             cnt_wr,
  input logic             bus_valid_i,
  input logic             bus_write_i,
  input logic             bus_addr_i,
  input logic             test_mode_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic [CNT_W-1:0] count_q,
  input logic             acc_tick_o,
  input logic             acc_stop_o
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((count_q != $past(count_q)) && !$past(cnt_wr)) |-> (count_q == $past(count_q) + 1'b1));

  p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!pre_tick && !acc_tick_o));

  p_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stop_o |-> !pre_tick);

  p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_i && bus_write_i && bus_addr_i && !test_mode_i && !pre_tick) |=> $stable(count_q));

  p_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prec_lock |=> $stable(prec));

  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_tick_o |=> !acc_tick_o);

  p_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_tick_o |-> pre_tick);

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count_q == $past(wr_data_i)));
endmodule

bind gated_tick_timer gtt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .en          (ctrl.en),
  .prec        (ctrl.prec),
  .prec_lock   (u_ctrl.lock_q),
  .pre_tick    (pre_tick),
  .cnt_wr      (cnt_wr),
  .bus_valid_i (bus_valid_i),
  .bus_write_i (bus_write_i),
  .bus_addr_i  (bus_addr_i),
  .test_mode_i (test_mode_i),
  .wr_data_i   (wr_data_i),
  .count_q     (count_q),
  .acc_tick_o  (acc_tick_o),
  .acc_stop_o  (acc_stop_o)
);

// File: tb/gated_tick_timer_test.sv
`timescale 1ns/1ps
module gated_tick_timer_test;
  localparam int PRE_DIV = 4;
  localparam int ACC_DIV = 64;

  logic        clk;
  logic        rst_n;
  logic        test_mode_i;
  logic        wait_i;
  logic        bus_valid_i;
  logic        bus_write_i;
  logic        bus_addr_i;
  logic [15:0] wr_data_i;
  logic [15:0] rd_data_o;
  logic        acc_tick_o;
  logic        acc_stop_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic live = 1'b0;

  gated_tick_timer uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .test_mode_i (test_mode_i),
    .wait_i      (wait_i),
    .bus_valid_i (bus_valid_i),
    .bus_write_i (bus_write_i),
    .bus_addr_i  (bus_addr_i),
    .wr_data_i   (wr_data_i),
    .rd_data_o   (rd_data_o),
    .acc_tick_o  (acc_tick_o),
    .acc_stop_o  (acc_stop_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Behavioural expectation built from the requirements.
  logic        m_en, m_halt, m_prec, m_lock;
  logic [15:0] m_cnt;
  int          m_ph, m_acc;
  logic        m_run, m_pt;

  assign m_run = m_en && !(m_halt && wait_i);
  assign m_pt  = m_run && (m_ph == PRE_DIV - 1);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= 1'b0; m_halt <= 1'b0; m_prec <= 1'b0; m_lock <= 1'b0;
      m_cnt <= '0; m_ph <= 0; m_acc <= 0;
    end else begin
      if (m_run) m_ph <= (m_ph + 1) % PRE_DIV;
      if (m_pt) m_acc <= (m_acc + 1) % ACC_DIV;
      if (bus_valid_i && bus_write_i && bus_addr_i && test_mode_i) m_cnt <= wr_data_i;
      else if (m_pt) m_cnt <= m_cnt + 16'd1;
      if (bus_valid_i && bus_write_i && !bus_addr_i) begin
        m_en <= wr_data_i[0];
        m_halt <= wr_data_i[1];
        if (!m_lock) m_prec <= wr_data_i[2];
        m_lock <= 1'b1;
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle output monitor, sampled away from both edges.
  always @(negedge clk) begin
    #2;
    if (live) begin
      chk("R7 acc tick", {15'd0, acc_tick_o}, {15'd0, m_pt && (m_acc == ACC_DIV - 1)});
      chk("R4 stop level", {15'd0, acc_stop_o}, {15'd0, m_halt && wait_i});
    end
  end

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    bus_valid_i = 1'b1; bus_write_i = 1'b1; bus_addr_i = a; wr_data_i = d;
    @(negedge clk);
    bus_valid_i = 1'b0; bus_write_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic rdc(input string tag, input logic a);
    logic [15:0] exp;
    @(negedge clk);
    bus_valid_i = 1'b1; bus_write_i = 1'b0; bus_addr_i = a;
    #1;
    exp = a ? m_cnt : {13'd0, m_prec, m_halt, m_en};
    chk(tag, rd_data_o, exp);
    bus_valid_i = 1'b0;
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; test_mode_i = 1'b0; wait_i = 1'b0;
    bus_valid_i = 1'b0; bus_write_i = 1'b0; bus_addr_i = 1'b0; wr_data_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    live = 1'b1;

    // R1: reset values
    rdc("R1 ctrl after reset", 1'b0);
    rdc("R1 count after reset", 1'b1);
    chk("R1 tick low", {15'd0, acc_tick_o}, 16'd0);
    chk("R1 stop low", {15'd0, acc_stop_o}, 16'd0);

    // R3: disabled counter holds
    for (int i = 0; i < 12; i++) rdc("R3 frozen while disabled", 1'b1);

    // R6/R2: first control write sets precision, enable on
    wr(1'b0, 16'h0005);
    rdc("R6 first write sets prec", 1'b0);
    for (int i = 0; i < 40; i++) rdc("R2 count per period", 1'b1);

    // R6/R9: later write cannot clear prec; upper bits read zero
    wr(1'b0, 16'hFFF9);
    rdc("R6 prec locked / R9 upper bits zero", 1'b0);

    // R9: idle bus reads zero
    @(negedge clk);
    bus_addr_i = 1'b1; bus_valid_i = 1'b0;
    #1 chk("R9 idle read zero", rd_data_o, 16'd0);

    // R7: run long enough for several accumulator pulses
    for (int i = 0; i < 600; i++) begin
      if (i % 50 == 0) rdc("R7 count during long run", 1'b1);
      else @(negedge clk);
    end

    // R5: count write ignored outside test mode
    wr(1'b1, 16'h1234);
    rdc("R5 write ignored", 1'b1);

    // R2/R8: load near top, cross the wrap
    test_mode_i = 1'b1;
    wr(1'b1, 16'hFFFD);
    for (int i = 0; i < 20; i++) rdc("R2 wrap / R8 load", 1'b1);

    // R8: loads at every prescaler phase offset
    for (int off = 0; off < PRE_DIV; off++) begin
      repeat (off) @(negedge clk);
      wr(1'b1, 16'h0100 + off[15:0]);
      for (int i = 0; i < 6; i++) rdc("R8 load keeps phase", 1'b1);
    end
    test_mode_i = 1'b0;

    // R4: wait with halt flag clear keeps counting
    @(negedge clk) wait_i = 1'b1;
    for (int i = 0; i < 12; i++) rdc("R4 counts in wait when halt clear", 1'b1);
    @(negedge clk) wait_i = 1'b0;

    // R4: halt flag set stalls during wait
    wr(1'b0, 16'h0003);
    @(negedge clk) wait_i = 1'b1;
    for (int i = 0; i < 12; i++) rdc("R4 halted in wait", 1'b1);
    @(negedge clk) wait_i = 1'b0;
    for (int i = 0; i < 10; i++) rdc("R4 resumes after wait", 1'b1);

    // R3: disable, then re-enable with held phase
    wr(1'b0, 16'h0000);
    for (int i = 0; i < 300; i++) begin
      if (i % 30 == 0) rdc("R3 frozen after disable", 1'b1);
      else @(negedge clk);
    end
    rdc("R6 prec still set", 1'b0);
    wr(1'b0, 16'h0001);
    for (int i = 0; i < 300; i++) rdc("R3 resume / R7 window", 1'b1);

    live = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule